// File: doc/BRIEF.md
# Bus-to-Wide-Memory DMA Mapper

This block lets peripherals on a 16-bit byte-addressed bus move data to and from a memory of 36-bit words. Each transfer request carries an 18-bit bus byte address, a byte count, a direction and a size (byte or 16-bit word). The block translates every element's address through a page map that the host programs. It then reads the addressed 36-bit word, inserts or extracts the byte or halfword at its fixed bit field, and writes the word back in the same cycle.

Four bus bytes fill one 36-bit word unevenly: byte lanes 0 to 3 sit at bit offsets 18, 26, 0 and 8. A halfword write keeps the two spare top bits of each 18-bit half. A translation that fails stops the transfer, sets a timeout flag and reports how many bytes were left. The same applies to an address that points past the end of memory. The memory is a small internal array that the host can load and inspect through its own port.

Top module: `wide_dma_mapper`

## Requirements
- R1: While and after reset, `busy`, `done`, `rd_valid` and `tmo` are 0 and every map entry reads back as 0. A reset also clears any map entries written before it.
- R2: A host map write to an index below 48 keeps only bits 15:12 of `map_wdata` (bit 15 is the valid flag) and bits 8:0 (the page frame). Bits 11:9 read back as 0. Writes to indices 48 to 63 have no effect, and those indices read as 0.
- R3: The word address is the bus address shifted right by 2. Word-address bits 15:9 form the page number and bits 8:0 the offset. The physical word is frame*512 + offset.
- R4: A byte element uses lane = address[1:0], which places it at bit offset 18, 26, 0 or 8 for lanes 0, 1, 2 and 3. A byte write changes only those 8 bits. A byte read returns them zero-extended on `rd_data`.
- R5: In word mode, address bit 0 and count bit 0 are cleared. Address bit 1 = 1 selects bits 15:0 and address bit 1 = 0 selects bits 33:18. A low-half write keeps bits 35:16, and a high-half write keeps bits 35:34 and 17:0.
- R6: A request is accepted at the edge where `req_valid` is 1 and `busy` is 0. Element k (counting from 0) is performed at the k+1-th edge after that. A successful transfer of N elements raises `done` for one cycle after edge N with `residual` = 0. Each read element raises `rd_valid` for one cycle.
- R7: An element fails if its page number is 48 or more, if bus address bit 17 is set, or if its map entry has the valid flag clear. The failing element is not performed. After the edge where it was due, `done` pulses, `tmo` becomes 1 and `residual` holds the bytes not yet moved, counting the failing element.
- R8: An element whose physical word address is 1024 or more fails in the same way as in R7.
- R9: `tmo` stays 1 until the next request is accepted, which clears it.
- R10: A request with no whole element (byte count 0, or word count below 2) completes with `done` one cycle after acceptance, with `residual` = 0 and no memory access.
- R11: A `req_valid` pulse while `busy` is 1 is ignored. The running transfer keeps its timing and target, and the second address is not touched.
- R12: During a write, element k takes its data from `wr_data` while `elem_idx` = k. `elem_idx` starts at 0 for each transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_we | input | 1 | Host map entry write strobe |
| map_addr | input | 6 | Map entry index for host write and read |
| map_wdata | input | 16 | Map entry write data |
| map_rdata | output | 16 | Map entry read data (combinational) |
| mem_we | input | 1 | Host memory write strobe |
| mem_addr | input | 10 | Host memory word address |
| mem_wdata | input | 36 | Host memory write data |
| mem_rdata | output | 36 | Host memory read data (combinational) |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = bus-to-memory write, 0 = memory-to-bus read |
| req_word | input | 1 | 1 = 16-bit elements, 0 = bytes |
| req_addr | input | 18 | Bus byte start address |
| req_count | input | 10 | Byte count |
| elem_idx | output | 10 | Index of the element in progress |
| wr_data | input | 16 | Write data for element `elem_idx` |
| rd_valid | output | 1 | Read element strobe |
| rd_data | output | 16 | Read element data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer strobe |
| residual | output | 10 | Bytes left at the end of the last transfer |
| tmo | output | 1 | Timeout flag: last transfer was aborted |

## Verification
Every result is tied to the edge where the request is accepted. Element k lands at edge k+1. `done` and the final `rd_valid` appear after edge N, or after the failing element's edge, and a transfer with no elements finishes after edge 1. The bench drives each request on a falling edge and then samples once per cycle on the falling edge. It counts the cycles until `done` and compares that count with the expected element or fault position, so a result that is one cycle early or late fails. Memory contents and map readbacks go through the combinational host ports while the block is idle, so no edge lies between the access and the sample.

// File: rtl/dmm_pkg.sv
package dmm_pkg;

   localparam int WORD_W = 36;
   localparam int LANE_W = 8;
   localparam int HALF_DATA_W = 16;

   // bit offset of byte lane within a wide word
   function automatic int unsigned lane_shift(input logic [1:0] lane);
      case (lane)
         2'd0:    return 18;
         2'd1:    return 26;
         2'd2:    return 0;
         default: return 8;
      endcase
   endfunction

   function automatic logic [WORD_W-1:0] put_byte(input logic [WORD_W-1:0] old,
                                                  input logic [1:0] lane,
                                                  input logic [LANE_W-1:0] b);
      logic [WORD_W-1:0] r;
      r = old;
      r[lane_shift(lane) +: LANE_W] = b;
      return r;
   endfunction

   function automatic logic [LANE_W-1:0] get_byte(input logic [WORD_W-1:0] w,
                                                  input logic [1:0] lane);
      return w[lane_shift(lane) +: LANE_W];
   endfunction

   // low_sel = address bit 1
   function automatic logic [WORD_W-1:0] put_half(input logic [WORD_W-1:0] old,
                                                  input logic low_sel,
                                                  input logic [HALF_DATA_W-1:0] h);
      logic [WORD_W-1:0] r;
      r = old;
      if (low_sel) r[15:0]  = h;
      else         r[33:18] = h;
      return r;
   endfunction

   function automatic logic [HALF_DATA_W-1:0] get_half(input logic [WORD_W-1:0] w,
                                                       input logic low_sel);
      return low_sel ? w[15:0] : w[33:18];
   endfunction

endpackage

// File: rtl/dmm_map_table.sv
module dmm_map_table #(
   parameter int ENTRIES = 48,
   parameter int IW      = 6,
   parameter int WA_W    = 16,
   parameter int PAGE_W  = 9,
   parameter int PA_W    = 18,
   parameter int DW      = 16,
   parameter int FLAG_W  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            host_we,
   input  logic [IW-1:0]   host_idx,
   input  logic [DW-1:0]   host_wdata,
   output logic [DW-1:0]   host_rdata,
   input  logic [WA_W-1:0] xl_wa,
   output logic [PA_W-1:0] xl_pa,
   output logic            xl_ok
);

   localparam int PFN_W = PA_W - PAGE_W;
   localparam int VPN_W = WA_W - PAGE_W;
   localparam int GAP_W = DW - FLAG_W - PFN_W;

   logic                vld_q [ENTRIES];
   logic [FLAG_W-2:0]   flg_q [ENTRIES];
   logic [PFN_W-1:0]    pfn_q [ENTRIES];

   logic                host_hit;
   logic [VPN_W-1:0]    vpn;
   logic [PAGE_W-1:0]   off;
   logic                in_range;
   logic                ent_vld;
   logic [PFN_W-1:0]    ent_pfn;

   assign host_hit = {1'b0, host_idx} < (IW+1)'(ENTRIES);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) begin
            vld_q[i] <= 1'b0;
            flg_q[i] <= '0;
            pfn_q[i] <= '0;
         end
      end else if (host_we && host_hit) begin
         vld_q[host_idx] <= host_wdata[DW-1];
         flg_q[host_idx] <= host_wdata[DW-2:DW-FLAG_W];
         pfn_q[host_idx] <= host_wdata[PFN_W-1:0];
      end
   end

   always_comb begin
      host_rdata = '0;
      if (host_hit)
         host_rdata = {vld_q[host_idx], flg_q[host_idx], {GAP_W{1'b0}}, pfn_q[host_idx]};
   end

   assign vpn = xl_wa[WA_W-1:PAGE_W];
   assign off = xl_wa[PAGE_W-1:0];

   generate
      if (ENTRIES >= (1 << VPN_W)) begin : g_full_map
         assign in_range = 1'b1;
      end else begin : g_part_map
         assign in_range = {1'b0, vpn} < (VPN_W+1)'(ENTRIES);
      end
   endgenerate

   assign ent_vld = vld_q[IW'(vpn)];
   assign ent_pfn = pfn_q[IW'(vpn)];

   assign xl_pa = {ent_pfn, {PAGE_W{1'b0}}} + {{PFN_W{1'b0}}, off};
   assign xl_ok = in_range && !xl_wa[WA_W-1] && ent_vld;

endmodule

// File: rtl/dmm_wide_mem.sv
module dmm_wide_mem #(
   parameter int WORDS = 1024,
   parameter int AW    = 10,
   parameter int PA_W  = 18,
   parameter int W     = 36
) (
   input  logic            clk,
   input  logic            dma_we,
   input  logic [PA_W-1:0] dma_pa,
   input  logic [W-1:0]    dma_wdata,
   output logic [W-1:0]    dma_rdata,
   output logic            dma_exists,
   input  logic            host_we,
   input  logic [AW-1:0]   host_addr,
   input  logic [W-1:0]    host_wdata,
   output logic [W-1:0]    host_rdata
);

   logic [W-1:0]  mem [WORDS];
   logic [AW-1:0] dma_idx;

   assign dma_idx = AW'(dma_pa);

   generate
      if (WORDS >= (1 << PA_W)) begin : g_full_space
         assign dma_exists = 1'b1;
      end else begin : g_part_space
         assign dma_exists = dma_pa < PA_W'(WORDS);
      end
   endgenerate

   assign dma_rdata  = mem[dma_idx];
   assign host_rdata = mem[host_addr];

   // transfer engine has priority over host loads
   always_ff @(posedge clk) begin
      if (dma_we)       mem[dma_idx]   <= dma_wdata;
      else if (host_we) mem[host_addr] <= host_wdata;
   end

endmodule

// File: rtl/dmm_lane_merge.sv
module dmm_lane_merge
   import dmm_pkg::*;
(
   input  logic [WORD_W-1:0]      old_word,
   input  logic [1:0]             lane,
   input  logic                   is_word,
   input  logic [HALF_DATA_W-1:0] wdata,
   output logic [WORD_W-1:0]      new_word,
   output logic [HALF_DATA_W-1:0] rdata
);

   always_comb begin
      if (is_word) begin
         new_word = put_half(old_word, lane[1], wdata);
         rdata    = get_half(old_word, lane[1]);
      end else begin
         new_word = put_byte(old_word, lane, wdata[LANE_W-1:0]);
         rdata    = {{(HALF_DATA_W-LANE_W){1'b0}}, get_byte(old_word, lane)};
      end
   end

endmodule

// File: rtl/dmm_xfer_ctrl.sv
module dmm_xfer_ctrl #(
   parameter int BUS_AW = 18,
   parameter int CNT_W  = 10,
   parameter int DW     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_word,
   input  logic [BUS_AW-1:0] req_addr,
   input  logic [CNT_W-1:0]  req_count,
   input  logic              xl_ok,
   input  logic [DW-1:0]     lane_rdata,
   output logic [BUS_AW-1:0] cur_addr,
   output logic              cur_word,
   output logic              acc_we,
   output logic [CNT_W-1:0]  elem_idx,
   output logic              rd_valid,
   output logic [DW-1:0]     rd_data,
   output logic              busy,
   output logic              done,
   output logic [CNT_W-1:0]  residual,
   output logic              tmo
);

   logic             run_q;
   logic             write_q;
   logic [CNT_W-1:0] remain_q;
   logic [CNT_W-1:0] step_c;
   logic [BUS_AW-1:0] step_a;
   logic             have_elem;

   assign step_c    = {{(CNT_W-2){1'b0}}, cur_word, !cur_word};
   assign step_a    = {{(BUS_AW-2){1'b0}}, cur_word, !cur_word};
   assign have_elem = remain_q != '0;
   assign acc_we    = run_q && have_elem && xl_ok && write_q;
   assign busy      = run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         write_q  <= 1'b0;
         cur_word <= 1'b0;
         cur_addr <= '0;
         remain_q <= '0;
         elem_idx <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
         done     <= 1'b0;
         residual <= '0;
         tmo      <= 1'b0;
      end else begin
         done     <= 1'b0;
         rd_valid <= 1'b0;
         if (!run_q) begin
            if (req_valid) begin
               run_q    <= 1'b1;
               write_q  <= req_write;
               cur_word <= req_word;
               cur_addr <= req_word ? {req_addr[BUS_AW-1:1], 1'b0} : req_addr;
               remain_q <= req_word ? {req_count[CNT_W-1:1], 1'b0} : req_count;
               elem_idx <= '0;
               tmo      <= 1'b0;
            end
         end else if (!have_elem) begin
            run_q    <= 1'b0;
            done     <= 1'b1;
            residual <= '0;
         end else if (!xl_ok) begin
            run_q    <= 1'b0;
            done     <= 1'b1;
            residual <= remain_q;
            tmo      <= 1'b1;
         end else begin
            rd_valid <= !write_q;
            rd_data  <= lane_rdata;
            cur_addr <= cur_addr + step_a;
            remain_q <= remain_q - step_c;
            elem_idx <= elem_idx + 1'b1;
            if (remain_q == step_c) begin
               run_q    <= 1'b0;
               done     <= 1'b1;
               residual <= '0;
            end
         end
      end
   end

endmodule

// File: rtl/wide_dma_mapper.sv
module wide_dma_mapper
   import dmm_pkg::*;
#(
   parameter int BUS_AW      = 18,
   parameter int PAGE_W      = 9,
   parameter int PA_W        = 18,
   parameter int MAP_ENTRIES = 48,
   parameter int MAP_DW      = 16,
   parameter int FLAG_W      = 4,
   parameter int MEM_WORDS   = 1024,
   parameter int CNT_W       = 10,
   localparam int MAP_IW     = $clog2(MAP_ENTRIES),
   localparam int MEM_AW     = $clog2(MEM_WORDS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   map_we,
   input  logic [MAP_IW-1:0]      map_addr,
   input  logic [MAP_DW-1:0]      map_wdata,
   output logic [MAP_DW-1:0]      map_rdata,
   input  logic                   mem_we,
   input  logic [MEM_AW-1:0]      mem_addr,
   input  logic [WORD_W-1:0]      mem_wdata,
   output logic [WORD_W-1:0]      mem_rdata,
   input  logic                   req_valid,
   input  logic                   req_write,
   input  logic                   req_word,
   input  logic [BUS_AW-1:0]      req_addr,
   input  logic [CNT_W-1:0]       req_count,
   output logic [CNT_W-1:0]       elem_idx,
   input  logic [HALF_DATA_W-1:0] wr_data,
   output logic                   rd_valid,
   output logic [HALF_DATA_W-1:0] rd_data,
   output logic                   busy,
   output logic                   done,
   output logic [CNT_W-1:0]       residual,
   output logic                   tmo
);

   localparam int WA_W = BUS_AW - 2;

   initial begin
      if (PA_W <= PAGE_W)                   $fatal(1, "physical width must exceed page width");
      if (WA_W <= PAGE_W)                   $fatal(1, "bus address too narrow for page size");
      if (MAP_DW - FLAG_W - (PA_W - PAGE_W) < 1) $fatal(1, "map entry too narrow");
      if (FLAG_W < 2)                       $fatal(1, "need valid flag plus one flag");
      if (CNT_W < 2)                        $fatal(1, "count too narrow");
      if (MEM_AW > PA_W)                    $fatal(1, "memory larger than physical space");
   end

   logic [BUS_AW-1:0]      cur_addr;
   logic                   cur_word;
   logic                   acc_we;
   logic [PA_W-1:0]        xl_pa;
   logic                   map_ok;
   logic                   mem_ok;
   logic [WORD_W-1:0]      old_word;
   logic [WORD_W-1:0]      new_word;
   logic [HALF_DATA_W-1:0] lane_rdata;

   dmm_map_table #(
      .ENTRIES (MAP_ENTRIES), .IW (MAP_IW), .WA_W (WA_W),
      .PAGE_W (PAGE_W), .PA_W (PA_W), .DW (MAP_DW), .FLAG_W (FLAG_W)
   ) u_map (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (map_we),
      .host_idx   (map_addr),
      .host_wdata (map_wdata),
      .host_rdata (map_rdata),
      .xl_wa      (cur_addr[BUS_AW-1:2]),
      .xl_pa      (xl_pa),
      .xl_ok      (map_ok)
   );

   dmm_wide_mem #(
      .WORDS (MEM_WORDS), .AW (MEM_AW), .PA_W (PA_W), .W (WORD_W)
   ) u_mem (
      .clk        (clk),
      .dma_we     (acc_we),
      .dma_pa     (xl_pa),
      .dma_wdata  (new_word),
      .dma_rdata  (old_word),
      .dma_exists (mem_ok),
      .host_we    (mem_we),
      .host_addr  (mem_addr),
      .host_wdata (mem_wdata),
      .host_rdata (mem_rdata)
   );

   dmm_lane_merge u_lane (
      .old_word (old_word),
      .lane     (cur_addr[1:0]),
      .is_word  (cur_word),
      .wdata    (wr_data),
      .new_word (new_word),
      .rdata    (lane_rdata)
   );

   dmm_xfer_ctrl #(
      .BUS_AW (BUS_AW), .CNT_W (CNT_W), .DW (HALF_DATA_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_word   (req_word),
      .req_addr   (req_addr),
      .req_count  (req_count),
      .xl_ok      (map_ok && mem_ok),
      .lane_rdata (lane_rdata),
      .cur_addr   (cur_addr),
      .cur_word   (cur_word),
      .acc_we     (acc_we),
      .elem_idx   (elem_idx),
      .rd_valid   (rd_valid),
      .rd_data    (rd_data),
      .busy       (busy),
      .done       (done),
      .residual   (residual),
      .tmo        (tmo)
   );

endmodule

// File: rtl/wide_dma_mapper_chk.sv
module wide_dma_mapper_chk #(
   parameter int CNT_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             busy,
   input logic             done,
   input logic             rd_valid,
   input logic             tmo,
   input logic [CNT_W-1:0] residual
);

   // R6
   req_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !busy |=> busy);

   // R6
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));

   // R6
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R6
   rd_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(busy));

   // R6
   ok_zero_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !tmo |-> residual == '0);

   // R7
   fault_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo) |-> done && residual != '0);

   // R9
   tmo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo && !(req_valid && !busy) |=> tmo);

endmodule

bind wide_dma_mapper wide_dma_mapper_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .busy      (busy),
   .done      (done),
   .rd_valid  (rd_valid),
   .tmo       (tmo),
   .residual  (residual)
);

// File: tb/wide_dma_mapper_tb.sv
module wide_dma_mapper_tb;

   localparam int CLK_P = 20;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        map_we;
   logic [5:0]  map_addr;
   logic [15:0] map_wdata;
   logic [15:0] map_rdata;
   logic        mem_we;
   logic [9:0]  mem_addr;
   logic [35:0] mem_wdata;
   logic [35:0] mem_rdata;
   logic        req_valid;
   logic        req_write;
   logic        req_word;
   logic [17:0] req_addr;
   logic [9:0]  req_count;
   logic [9:0]  elem_idx;
   logic [15:0] wr_data;
   logic        rd_valid;
   logic [15:0] rd_data;
   logic        busy;
   logic        done;
   logic [9:0]  residual;
   logic        tmo;

   always #(CLK_P/2) clk = ~clk;

   wide_dma_mapper u_dut (.*);

   logic [15:0] wbuf [16];
   logic [15:0] rbuf [16];
   int          nrd;
   int          checks = 0;
   int          fails  = 0;

   assign wr_data = wbuf[elem_idx[3:0]];

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // independent model of lane placement
   function automatic logic [35:0] e_byte(input logic [35:0] old, input logic [17:0] ba,
                                          input logic [7:0] b);
      int s;
      logic [63:0] m, r;
      case (ba[1:0])
         2'd0: s = 18;
         2'd1: s = 26;
         2'd2: s = 0;
         default: s = 8;
      endcase
      m = 64'hFF << s;
      r = ({28'b0, old} & ~m) | ({56'b0, b} << s);
      return r[35:0];
   endfunction

   function automatic logic [35:0] e_word(input logic [35:0] old, input logic [17:0] ba,
                                          input logic [15:0] w);
      if (ba[1]) return {old[35:16], w};
      return {old[35:34], w, old[17:0]};
   endfunction

   task automatic map_wr(input logic [5:0] i, input logic [15:0] d);
      @(negedge clk); map_we = 1'b1; map_addr = i; map_wdata = d;
      @(negedge clk); map_we = 1'b0;
   endtask

   task automatic map_rd(input logic [5:0] i, output logic [15:0] d);
      @(negedge clk); map_addr = i; #1; d = map_rdata;
   endtask

   task automatic mem_wr(input logic [9:0] a, input logic [35:0] d);
      @(negedge clk); mem_we = 1'b1; mem_addr = a; mem_wdata = d;
      @(negedge clk); mem_we = 1'b0;
   endtask

   task automatic mem_rd(input logic [9:0] a, output logic [35:0] d);
      @(negedge clk); mem_addr = a; #1; d = mem_rdata;
   endtask

   // runs one request; cyc = edges from acceptance until done is seen
   task automatic xfer(input bit wr, input bit wd, input logic [17:0] a,
                       input logic [9:0] n, input bit poke, output int cyc);
      @(negedge clk);
      req_write = wr; req_word = wd; req_addr = a; req_count = n; req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      nrd = 0;
      cyc = 0;
      while (1) begin
         @(posedge clk);
         @(negedge clk);
         cyc++;
         if (rd_valid) begin
            if (nrd < 16) rbuf[nrd] = rd_data;
            nrd++;
         end
         if (done) break;
         if (poke && cyc == 1) begin
            req_valid = 1'b1; req_addr = 18'h20; req_count = 10'd8;
         end
         if (poke && cyc == 2) req_valid = 1'b0;
         if (cyc > 100) break;
      end
   endtask

   task automatic t_reset;
      logic [15:0] d;
      chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);
      chk("R1 tmo", tmo, 0);
      chk("R1 rd_valid", rd_valid, 0);
      map_rd(6'd0, d);  chk("R1 map0", d, 0);
      map_rd(6'd47, d); chk("R1 map47", d, 0);
   endtask

   task automatic t_map_mask;
      logic [15:0] d;
      map_wr(6'd3, 16'hFFFF);
      map_rd(6'd3, d);  chk("R2 kept fields", d, 16'hF1FF);
      map_wr(6'd50, 16'hFFFF);
      map_rd(6'd50, d); chk("R2 beyond table", d, 16'h0000);
      map_wr(6'd3, 16'h0000);
   endtask

   task automatic t_bytes;
      int c;
      logic [35:0] m, e;
      mem_wr(10'd3, 36'hF_FFFF_FFFF);
      wbuf[0] = 16'h0011; wbuf[1] = 16'h0022; wbuf[2] = 16'h0033; wbuf[3] = 16'h0044;
      xfer(1, 0, 18'd12, 10'd4, 0, c);
      chk("R6 byte write cycles", c, 4);
      chk("R6 residual", residual, 0);
      chk("R12 no rd on write", nrd, 0);
      e = 36'hF_FFFF_FFFF;
      for (int k = 0; k < 4; k++) e = e_byte(e, 18'(12 + k), wbuf[k][7:0]);
      mem_rd(10'd3, m);
      chk("R4 byte lanes", m, e);
      xfer(0, 0, 18'd13, 10'd3, 0, c);
      chk("R6 byte read cycles", c, 3);
      chk("R6 read count", nrd, 3);
      chk("R4 read lane1", rbuf[0], 16'h0022);
      chk("R4 read lane2", rbuf[1], 16'h0033);
      chk("R4 read lane3", rbuf[2], 16'h0044);
   endtask

   task automatic t_words;
      int c;
      logic [35:0] m, e;
      mem_wr(10'd5, 36'hF_FFFF_FFFF);
      wbuf[0] = 16'h1234; wbuf[1] = 16'hABCD;
      xfer(1, 1, 18'd20, 10'd4, 0, c);
      chk("R6 word write cycles", c, 2);
      e = e_word(e_word(36'hF_FFFF_FFFF, 18'd20, 16'h1234), 18'd22, 16'hABCD);
      mem_rd(10'd5, m);
      chk("R5 halves keep spare bits", m, e);
      xfer(0, 1, 18'd20, 10'd4, 0, c);
      chk("R5 read high half", rbuf[0], 16'h1234);
      chk("R5 read low half", rbuf[1], 16'hABCD);
      mem_wr(10'd6, 36'h0);
      wbuf[0] = 16'h5A5A;
      xfer(1, 1, 18'd25, 10'd3, 0, c);
      chk("R5 aligned single word cycles", c, 1);
      chk("R5 aligned residual", residual, 0);
      mem_rd(10'd6, m);
      chk("R5 aligned to high half", m, {2'b00, 16'h5A5A, 18'h0});
   endtask

   task automatic t_pages;
      int c;
      logic [35:0] m;
      mem_wr(10'd513, 36'h0);
      mem_wr(10'd1, 36'h0);
      wbuf[0] = 16'h00C3;
      xfer(1, 0, 18'h805, 10'd1, 0, c);
      mem_rd(10'd513, m);
      chk("R3 page 1 frame 1", m, 36'h0C3 << 26);
      mem_rd(10'd1, m);
      chk("R3 frame 0 untouched", m, 36'h0);
      map_wr(6'd47, 16'h8000);
      mem_wr(10'd0, 36'h0_0000_00A5);
      xfer(0, 0, 18'h17802, 10'd1, 0, c);
      chk("R3 last entry cycles", c, 1);
      chk("R3 last entry data", rbuf[0], 16'h00A5);
   endtask

   task automatic t_faults;
      int c;
      logic [35:0] m;
      xfer(1, 0, 18'h1000, 10'd4, 0, c);
      chk("R7 invalid entry cycles", c, 1);
      chk("R7 invalid residual", residual, 4);
      chk("R7 tmo set", tmo, 1);
      mem_wr(10'd1023, 36'h0);
      wbuf[0] = 16'h0077; wbuf[1] = 16'h0088; wbuf[2] = 16'h0099; wbuf[3] = 16'h00AA;
      xfer(1, 0, 18'hFFE, 10'd4, 0, c);
      chk("R9 tmo cleared then set", tmo, 1);
      chk("R7 mid fault cycles", c, 3);
      chk("R7 mid fault residual", residual, 2);
      mem_rd(10'd1023, m);
      chk("R7 elements before fault kept", m, 36'h0_0000_8877);
      xfer(0, 0, 18'h20000, 10'd2, 0, c);
      chk("R7 bit17 residual", residual, 2);
      chk("R7 bit17 no data", nrd, 0);
      xfer(0, 0, 18'h19000, 10'd2, 0, c);
      chk("R7 page beyond map", residual, 2);
      xfer(0, 1, 18'h2000, 10'd6, 0, c);
      chk("R8 nxm cycles", c, 1);
      chk("R8 nxm residual", residual, 6);
      chk("R8 nxm tmo", tmo, 1);
      xfer(0, 0, 18'd12, 10'd1, 0, c);
      chk("R9 tmo cleared", tmo, 0);
   endtask

   task automatic t_zero;
      int c;
      xfer(0, 0, 18'd0, 10'd0, 0, c);
      chk("R10 zero count cycles", c, 1);
      chk("R10 zero residual", residual, 0);
      chk("R10 no data", nrd, 0);
      xfer(0, 1, 18'd0, 10'd1, 0, c);
      chk("R10 short word cycles", c, 1);
      chk("R10 short word no data", nrd, 0);
   endtask

   task automatic t_busy_ignore;
      int c;
      logic [35:0] m, e;
      mem_wr(10'd7, 36'h0);
      mem_wr(10'd8, 36'h0);
      wbuf[0] = 16'h0001; wbuf[1] = 16'h0002; wbuf[2] = 16'h0003; wbuf[3] = 16'h0004;
      wbuf[4] = 16'h00EE; wbuf[5] = 16'h00EE; wbuf[6] = 16'h00EE; wbuf[7] = 16'h00EE;
      xfer(1, 0, 18'd28, 10'd4, 1, c);
      chk("R11 cycles unchanged", c, 4);
      e = 36'h0;
      for (int k = 0; k < 4; k++) e = e_byte(e, 18'(28 + k), wbuf[k][7:0]);
      mem_rd(10'd7, m);
      chk("R12 data by elem_idx", m, e);
      mem_rd(10'd8, m);
      chk("R11 second target untouched", m, 36'h0);
      repeat (3) @(negedge clk);
      chk("R11 no late start", busy, 0);
   endtask

   task automatic t_reset_clears;
      logic [15:0] d;
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      map_rd(6'd0, d);  chk("R1 map0 cleared", d, 0);
      map_rd(6'd47, d); chk("R1 map47 cleared", d, 0);
   endtask

   initial begin
      #(CLK_P * 100000);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; map_we = 1'b0; map_addr = '0; map_wdata = '0;
      mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
      req_valid = 1'b0; req_write = 1'b0; req_word = 1'b0; req_addr = '0; req_count = '0;
      for (int k = 0; k < 16; k++) begin wbuf[k] = '0; rbuf[k] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_reset();
      map_wr(6'd0, 16'h8000);
      map_wr(6'd1, 16'h8001);
      map_wr(6'd2, 16'h0003);
      map_wr(6'd4, 16'h8005);
      t_map_mask();
      t_bytes();
      t_words();
      t_pages();
      t_faults();
      t_zero();
      t_busy_ignore();
      t_reset_clears();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule